// File: doc/BRIEF.md
# General-Purpose I/O Port with Atomic Bit Set/Clear

This block is a sixteen-pin general-purpose I/O port that is configured through a small word-addressed register bus. The bus has an address, a write strobe, write data and read data, and it completes a read or a write in one cycle. Each pin has its own settings:

- a 2-bit mode: input, output, alternate function or analog;
- a push-pull or open-drain output type;
- a 2-bit speed code;
- a 2-bit pull setting;
- a 4-bit selector that picks one of sixteen alternate-function sources.

From these settings the port drives a set of pad-side signals for every pin: output level, output enable, open-drain flag, pull-up enable, pull-down enable and speed code. Pad inputs pass through a two-flop synchroniser and can be read back whatever the mode of the pin.

Output levels can be changed in two ways. Software can write the output-level word directly. It can also use a write-only set/clear word that changes chosen bits in a single write, without a read-modify-write sequence that could race with other software. The reset line is asynchronous and active-low, and the block releases it internally in step with the clock.

Top module: `gpio_port`

## Requirements
- R1: After reset, every register reads zero and every pin is an input with no pull: pad_oe, pad_pu and pad_pd are all zero, and pad_speed is zero.
- R2: The mode word at byte offset 0x00 holds two bits per pin, at bit 2*pin. The codes are 0 input, 1 output, 2 alternate function and 3 analog. The word reads back what was last written to it.
- R3: pad_oe of a pin can be high only when its mode is output or alternate function. In input and analog modes, pad_oe of that pin is low.
- R4: A write to offset 0x18 changes output levels. Data bit n (0..15) sets output bit n to 1. Data bit n+16 clears output bit n to 0. Output bits whose two data bits are both 0 keep their value. Offset 0x18 reads as zero.
- R5: If a write to offset 0x18 has both the set bit and the clear bit of the same pin, the pin is set to 1.
- R6: The output-type word at offset 0x04 holds one bit per pin in bits 15:0, where 1 means open-drain. pad_od follows this bit. An open-drain pin drives (pad_oe=1) only while its selected level is 0.
- R7: The pull word at offset 0x0C holds two bits per pin at bit 2*pin. Code 1 raises pad_pu and code 2 raises pad_pd. Codes 0 and 3 raise neither.
- R8: The speed word at offset 0x08 holds two bits per pin at bit 2*pin, and drives pad_speed unchanged.
- R9: Each pin has a 4-bit source selector. Pins 0–7 use the word at offset 0x20 and pins 8–15 use the word at offset 0x24, each at bit 4*(pin mod 8). In alternate-function mode, pad_out of pin n is af_src[16*n + selector]. In every other mode, pad_out is the pin's output-level bit.
- R10: Bit n of the input word at offset 0x10 shows pad_in[n] after two rising clock edges, in every mode.
- R11: Writes to the input word at 0x10, to offset 0x1C and to offsets 0x28 and above change no register and no pad output. Offsets 0x1C and 0x28 and above read as zero.
- R12: The output-level word at offset 0x14 holds bits 15:0. It can be read and written, and it gives the level for pins in output mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address; bits 1:0 are ignored |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, in the same cycle |
| pad_in | input | 16 | Levels from the pads, not synchronised |
| af_src | input | 256 | Alternate-function sources, 16 per pin, pin n at bits 16n+15:16n |
| pad_out | output | 16 | Output level for each pin |
| pad_oe | output | 16 | Output enable for each pin |
| pad_od | output | 16 | Open-drain flag for each pin |
| pad_pu | output | 16 | Pull-up enable for each pin |
| pad_pd | output | 16 | Pull-down enable for each pin |
| pad_speed | output | 32 | Speed code, 2 bits per pin |

## Verification
The bench builds the port with its default parameters: 16 pins, a 6-bit byte address, a 32-bit data word, 16 alternate-function sources per pin and two synchroniser stages. These values mean that every pin position is reached. This includes pin 15, whose clear bit is the top bit of the data word, and both halves of the selector words. The 6-bit address also covers the unused offsets above the register map, so the bench can check that they are ignored. Two synchroniser stages make the input latency a fixed two edges, which the bench samples on both sides.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    MODE_IN  = 2'd0,
    MODE_OUT = 2'd1,
    MODE_ALT = 2'd2,
    MODE_ANA = 2'd3
  } pin_mode_e;

  typedef enum logic [1:0] {
    PULL_NONE = 2'd0,
    PULL_UP   = 2'd1,
    PULL_DOWN = 2'd2,
    PULL_RSVD = 2'd3
  } pin_pull_e;

  // byte offsets of the register words
  localparam logic [7:0] OFF_MODE  = 8'h00;
  localparam logic [7:0] OFF_OTYPE = 8'h04;
  localparam logic [7:0] OFF_SPEED = 8'h08;
  localparam logic [7:0] OFF_PULL  = 8'h0C;
  localparam logic [7:0] OFF_IN    = 8'h10;
  localparam logic [7:0] OFF_OUT   = 8'h14;
  localparam logic [7:0] OFF_SETCL = 8'h18;
  localparam logic [7:0] OFF_SELLO = 8'h20;
  localparam logic [7:0] OFF_SELHI = 8'h24;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  always_comb begin
    chain_d[0] = raw_i;
    for (int s = 1; s < STAGES; s++) begin
      chain_d[s] = chain_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32,
  parameter int SEL_W    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [NUM_PINS-1:0]        pin_level_i,
  output logic [2*NUM_PINS-1:0]      mode_o,
  output logic [NUM_PINS-1:0]        otype_o,
  output logic [2*NUM_PINS-1:0]      speed_o,
  output logic [2*NUM_PINS-1:0]      pull_o,
  output logic [SEL_W*NUM_PINS-1:0]  afsel_o,
  output logic [NUM_PINS-1:0]        out_level_o
);

  localparam int FIELD2_W = 2 * NUM_PINS;
  localparam int HALF     = NUM_PINS / 2;
  localparam int SELH_W   = SEL_W * HALF;

  logic [7:0] reg_off;

  logic [FIELD2_W-1:0] mode_q, mode_d;
  logic [NUM_PINS-1:0] otype_q, otype_d;
  logic [FIELD2_W-1:0] speed_q, speed_d;
  logic [FIELD2_W-1:0] pull_q, pull_d;
  logic [SELH_W-1:0]   sello_q, sello_d;
  logic [SELH_W-1:0]   selhi_q, selhi_d;
  logic [NUM_PINS-1:0] out_q, out_d;

  logic mode_en, otype_en, speed_en, pull_en, sello_en, selhi_en, out_en;
  logic wr_out, wr_setcl;
  logic [NUM_PINS-1:0] set_bits, clr_bits;

  // byte offset of the addressed word, low two address bits dropped
  always_comb begin
    reg_off = 8'({bus_addr[ADDR_W-1:2], 2'b00});
  end

  // next-state and clock enables
  always_comb begin
    mode_en  = bus_wr && (reg_off == OFF_MODE);
    otype_en = bus_wr && (reg_off == OFF_OTYPE);
    speed_en = bus_wr && (reg_off == OFF_SPEED);
    pull_en  = bus_wr && (reg_off == OFF_PULL);
    sello_en = bus_wr && (reg_off == OFF_SELLO);
    selhi_en = bus_wr && (reg_off == OFF_SELHI);
    wr_out   = bus_wr && (reg_off == OFF_OUT);
    wr_setcl = bus_wr && (reg_off == OFF_SETCL);
    out_en   = wr_out || wr_setcl;

    mode_d  = bus_wdata[FIELD2_W-1:0];
    otype_d = bus_wdata[NUM_PINS-1:0];
    speed_d = bus_wdata[FIELD2_W-1:0];
    pull_d  = bus_wdata[FIELD2_W-1:0];
    sello_d = bus_wdata[SELH_W-1:0];
    selhi_d = bus_wdata[SELH_W-1:0];

    set_bits = bus_wdata[NUM_PINS-1:0];
    clr_bits = bus_wdata[2*NUM_PINS-1:NUM_PINS];
    if (wr_out) begin
      out_d = bus_wdata[NUM_PINS-1:0];
    end else begin
      // set is applied after clear so that it wins on a conflict
      out_d = (out_q & ~clr_bits) | set_bits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      otype_q <= '0;
      speed_q <= '0;
      pull_q  <= '0;
      sello_q <= '0;
      selhi_q <= '0;
      out_q   <= '0;
    end else begin
      if (mode_en)  mode_q  <= mode_d;
      if (otype_en) otype_q <= otype_d;
      if (speed_en) speed_q <= speed_d;
      if (pull_en)  pull_q  <= pull_d;
      if (sello_en) sello_q <= sello_d;
      if (selhi_en) selhi_q <= selhi_d;
      if (out_en)   out_q   <= out_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (reg_off)
      OFF_MODE:  bus_rdata[FIELD2_W-1:0] = mode_q;
      OFF_OTYPE: bus_rdata[NUM_PINS-1:0] = otype_q;
      OFF_SPEED: bus_rdata[FIELD2_W-1:0] = speed_q;
      OFF_PULL:  bus_rdata[FIELD2_W-1:0] = pull_q;
      OFF_IN:    bus_rdata[NUM_PINS-1:0] = pin_level_i;
      OFF_OUT:   bus_rdata[NUM_PINS-1:0] = out_q;
      OFF_SELLO: bus_rdata[SELH_W-1:0]   = sello_q;
      OFF_SELHI: bus_rdata[SELH_W-1:0]   = selhi_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign mode_o      = mode_q;
  assign otype_o     = otype_q;
  assign speed_o     = speed_q;
  assign pull_o      = pull_q;
  assign afsel_o     = {selhi_q, sello_q};
  assign out_level_o = out_q;

  AST_SETCL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_setcl |=> ((out_q & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0]))); // R5

  AST_SETCL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_setcl |=> ((out_q & $past(bus_wdata[2*NUM_PINS-1:NUM_PINS])
                   & ~$past(bus_wdata[NUM_PINS-1:0])) == '0)); // R4

  AST_SETCL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_setcl |=> (((out_q ^ $past(out_q)) & ~($past(bus_wdata[NUM_PINS-1:0])
                   | $past(bus_wdata[2*NUM_PINS-1:NUM_PINS]))) == '0)); // R4

  AST_SETCL_RDZ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_off == OFF_SETCL) |-> (bus_rdata == '0)); // R4

  AST_IN_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (reg_off == OFF_IN)) |=> ($stable(mode_q) && $stable(out_q) && $stable(otype_q)
                                         && $stable(pull_q))); // R11

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_port_pkg::*;
#(
  parameter int AF_NUM = 16,
  parameter int SEL_W  = 4
) (
  input  logic [1:0]        mode_i,
  input  logic              otype_i,
  input  logic [1:0]        pull_i,
  input  logic [SEL_W-1:0]  afsel_i,
  input  logic              out_level_i,
  input  logic [AF_NUM-1:0] af_src_i,
  output logic              pad_out_o,
  output logic              pad_oe_o,
  output logic              pad_od_o,
  output logic              pad_pu_o,
  output logic              pad_pd_o
);

  pin_mode_e md;
  pin_pull_e pl;
  logic      drive_mode;
  logic      level;

  always_comb begin
    md         = pin_mode_e'(mode_i);
    pl         = pin_pull_e'(pull_i);
    drive_mode = (md == MODE_OUT) || (md == MODE_ALT);
    level      = (md == MODE_ALT) ? af_src_i[afsel_i] : out_level_i;
    pad_out_o  = level;
    pad_od_o   = otype_i;
    // open-drain pins only pull low
    pad_oe_o   = drive_mode && (!otype_i || !level);
    pad_pu_o   = (pl == PULL_UP);
    pad_pd_o   = (pl == PULL_DOWN);
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 32,
  parameter int AF_NUM      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [NUM_PINS-1:0]        pad_in,
  input  logic [NUM_PINS*AF_NUM-1:0] af_src,
  output logic [NUM_PINS-1:0]        pad_out,
  output logic [NUM_PINS-1:0]        pad_oe,
  output logic [NUM_PINS-1:0]        pad_od,
  output logic [NUM_PINS-1:0]        pad_pu,
  output logic [NUM_PINS-1:0]        pad_pd,
  output logic [2*NUM_PINS-1:0]      pad_speed
);

  localparam int SEL_W = $clog2(AF_NUM);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [NUM_PINS-1:0]       pin_level;
  logic [2*NUM_PINS-1:0]     mode_w;
  logic [NUM_PINS-1:0]       otype_w;
  logic [2*NUM_PINS-1:0]     pull_w;
  logic [SEL_W*NUM_PINS-1:0] afsel_w;
  logic [NUM_PINS-1:0]       out_level_w;

  gpio_in_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_in_sync (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .raw_i  (pad_in),
    .sync_o (pin_level)
  );

  gpio_regfile #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SEL_W    (SEL_W)
  ) u_regfile (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pin_level_i (pin_level),
    .mode_o      (mode_w),
    .otype_o     (otype_w),
    .speed_o     (pad_speed),
    .pull_o      (pull_w),
    .afsel_o     (afsel_w),
    .out_level_o (out_level_w)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_pin_ctrl #(
      .AF_NUM (AF_NUM),
      .SEL_W  (SEL_W)
    ) u_pin (
      .mode_i      (mode_w[2*p +: 2]),
      .otype_i     (otype_w[p]),
      .pull_i      (pull_w[2*p +: 2]),
      .afsel_i     (afsel_w[SEL_W*p +: SEL_W]),
      .out_level_i (out_level_w[p]),
      .af_src_i    (af_src[AF_NUM*p +: AF_NUM]),
      .pad_out_o   (pad_out[p]),
      .pad_oe_o    (pad_oe[p]),
      .pad_od_o    (pad_od[p]),
      .pad_pu_o    (pad_pu[p]),
      .pad_pd_o    (pad_pd[p])
    );

    AST_OE_MODE: assert property (@(posedge clk) disable iff (!rst_sync_q)
      pad_oe[p] |-> (mode_w[2*p +: 2] == MODE_OUT || mode_w[2*p +: 2] == MODE_ALT)); // R3

    AST_PP_DRIVES: assert property (@(posedge clk) disable iff (!rst_sync_q)
      ((mode_w[2*p +: 2] == MODE_OUT) && !pad_od[p]) |-> pad_oe[p]); // R3

    AST_OD_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_sync_q)
      (pad_oe[p] && pad_od[p]) |-> !pad_out[p]); // R6

    AST_PULL_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_q)
      !(pad_pu[p] && pad_pd[p])); // R7
  end

endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;

  localparam int CLK_PERIOD = 10;

  logic         clk;
  logic         rst_n;
  logic [5:0]   bus_addr;
  logic         bus_wr;
  logic [31:0]  bus_wdata;
  logic [31:0]  bus_rdata;
  logic [15:0]  pad_in;
  logic [255:0] af_src;
  logic [15:0]  pad_out, pad_oe, pad_od, pad_pu, pad_pd;
  logic [31:0]  pad_speed;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench model of the register state
  logic [31:0] m_mode, m_speed, m_pull, m_sello, m_selhi;
  logic [15:0] m_ot, m_out, m_in;

  gpio_port u_gpio_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .af_src    (af_src),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_od    (pad_od),
    .pad_pu    (pad_pu),
    .pad_pd    (pad_pd),
    .pad_speed (pad_speed)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] off);
    case (off)
      8'h00:   return m_mode;
      8'h04:   return {16'h0, m_ot};
      8'h08:   return m_speed;
      8'h0C:   return m_pull;
      8'h10:   return {16'h0, m_in};
      8'h14:   return {16'h0, m_out};
      8'h20:   return m_sello;
      8'h24:   return m_selhi;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] off);
    case (off)
      8'h00:   return "R2 mode readback";
      8'h04:   return "R6 otype readback";
      8'h08:   return "R8 speed readback";
      8'h0C:   return "R7 pull readback";
      8'h10:   return "R10 input readback";
      8'h14:   return "R12 out readback";
      8'h18:   return "R4 setclr reads zero";
      8'h20, 8'h24: return "R9 selector readback";
      default: return "R11 hole reads zero";
    endcase
  endfunction

  function automatic void model_write(input logic [7:0] off, input logic [31:0] d);
    case (off)
      8'h00: m_mode  = d;
      8'h04: m_ot    = d[15:0];
      8'h08: m_speed = d;
      8'h0C: m_pull  = d;
      8'h14: m_out   = d[15:0];
      8'h18: m_out   = (m_out & ~d[31:16]) | d[15:0];
      8'h20: m_sello = d;
      8'h24: m_selhi = d;
      default: ;
    endcase
  endfunction

  task automatic bus_write(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = off[5:0];
    bus_wr    = 1'b1;
    bus_wdata = d;
    @(negedge clk);
    bus_wr    = 1'b0;
    model_write(off, d);
  endtask

  task automatic bus_read_chk(input logic [7:0] off, input string tag);
    bus_addr = off[5:0];
    bus_wr   = 1'b0;
    #1;
    chk(tag, bus_rdata, exp_read(off));
  endtask

  task automatic read_all(input string prefix);
    for (int w = 0; w < 16; w++) begin
      bus_read_chk(8'(w * 4), {prefix, tag_of(8'(w * 4))});
    end
  endtask

  task automatic pads_chk(input string prefix);
    logic [15:0] e_out, e_oe, e_pu, e_pd;
    #1;
    for (int i = 0; i < 16; i++) begin
      logic [1:0] md;
      logic [1:0] pl;
      logic [3:0] sel;
      logic       val;
      md  = m_mode[2*i +: 2];
      pl  = m_pull[2*i +: 2];
      sel = (i < 8) ? m_sello[4*i +: 4] : m_selhi[4*(i-8) +: 4];
      val = (md == 2'd2) ? af_src[16*i + int'(sel)] : m_out[i];
      e_out[i] = val;
      e_oe[i]  = ((md == 2'd1) || (md == 2'd2)) && (!m_ot[i] || !val);
      e_pu[i]  = (pl == 2'd1);
      e_pd[i]  = (pl == 2'd2);
    end
    chk({prefix, "R9 pad_out"},  {16'h0, pad_out}, {16'h0, e_out});
    chk({prefix, "R3 pad_oe"},   {16'h0, pad_oe},  {16'h0, e_oe});
    chk({prefix, "R6 pad_od"},   {16'h0, pad_od},  {16'h0, m_ot});
    chk({prefix, "R7 pad_pu"},   {16'h0, pad_pu},  {16'h0, e_pu});
    chk({prefix, "R7 pad_pd"},   {16'h0, pad_pd},  {16'h0, e_pd});
    chk({prefix, "R8 pad_speed"}, pad_speed, m_speed);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_mode = '0; m_speed = '0; m_pull = '0; m_sello = '0; m_selhi = '0;
    m_ot = '0; m_out = '0; m_in = '0;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    pad_in = '0; af_src = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    read_all("R1 reset ");
    pads_chk("R1 reset ");
    chk("R1 reset pad_oe zero", {16'h0, pad_oe}, 32'h0);

    // R2 / R3: all pins output, then analog
    bus_write(8'h00, 32'h5555_5555);
    bus_read_chk(8'h00, "R2 mode all output");
    pads_chk("R3 output ");
    bus_write(8'h00, 32'hFFFF_FFFF);
    pads_chk("R3 analog ");
    chk("R3 analog no drive", {16'h0, pad_oe}, 32'h0);
    bus_write(8'h00, 32'h5555_5555);

    // R4: set, clear, untouched bits, read zero
    bus_write(8'h18, 32'h0000_80FF);
    chk("R4 set bits", {16'h0, pad_out}, 32'h0000_80FF);
    bus_write(8'h18, 32'h800F_0000);
    chk("R4 clear bits", {16'h0, pad_out}, 32'h0000_00F0);
    bus_read_chk(8'h18, "R4 setclr reads zero");

    // R5: set and clear on the same pin
    bus_write(8'h18, 32'h0210_0210);
    chk("R5 set wins", {16'h0, pad_out}, 32'h0000_02F0);
    pads_chk("R5 ");

    // R12: direct output word
    bus_write(8'h14, 32'hFFFF_A5C3);
    bus_read_chk(8'h14, "R12 out direct write");
    pads_chk("R12 ");

    // R6: open-drain drives only low
    bus_write(8'h04, 32'h0000_FFFF);
    chk("R6 od level1 no drive", {16'h0, pad_oe}, {16'h0, ~16'hA5C3});
    bus_write(8'h14, 32'h0000_0000);
    chk("R6 od level0 drives", {16'h0, pad_oe}, 32'h0000_FFFF);
    bus_write(8'h04, 32'h0);

    // R10: two-edge input latency
    @(negedge clk);
    pad_in = 16'hBEEF;
    bus_addr = 6'h10;
    @(negedge clk);
    #1;
    chk("R10 one edge old value", bus_rdata, 32'h0);
    @(negedge clk);
    #1;
    chk("R10 two edges new value", bus_rdata, 32'h0000_BEEF);
    m_in = 16'hBEEF;

    // R11: writes to input word and holes ignored
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_write(8'h1C, 32'hFFFF_FFFF);
    bus_write(8'h3C, 32'hFFFF_FFFF);
    read_all("R11 after ignored writes ");
    pads_chk("R11 ");

    // R9: selectors in both halves
    bus_write(8'h00, 32'hAAAA_AAAA);
    bus_write(8'h20, 32'h7654_3210);
    bus_write(8'h24, 32'hFEDC_BA98);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      af_src = '0;
      for (int i = 0; i < 16; i++) af_src[16*i + k] = 1'b1;
      pads_chk("R9 walk ");
    end

    // random traffic
    for (int it = 0; it < 500; it++) begin
      int op;
      logic [31:0] d;
      op = int'($urandom_range(0, 12));
      d  = $urandom;
      if (op <= 9) begin
        bus_write(8'(op * 4), d);
      end else if (op == 10) begin
        bus_write(8'(8'h28 + 4 * $urandom_range(0, 5)), d);
      end else if (op == 11) begin
        @(negedge clk);
        for (int j = 0; j < 8; j++) af_src[32*j +: 32] = $urandom;
      end else begin
        @(negedge clk);
        pad_in = d[15:0];
        repeat (2) @(negedge clk);
        m_in = d[15:0];
      end
      pads_chk("rand ");
      if ((it % 25) == 0) read_all("rand ");
    end
    read_all("final ");

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule